// File: doc/BRIEF.md
# Multicycle 32-bit Load/Store Processor Core

This block is a compact 32-bit processor core that runs one instruction at a time. Each instruction passes through a fixed sequence of controller states. It holds 32 general registers and a program counter. It talks to memory over a single word-wide bus. The bus carries a read strobe, a write strobe, a two-bit access size, a sign-extension request and a ready handshake. The core fetches, decodes and executes register and immediate arithmetic and logic, a load-upper-half instruction, equality and unsigned compare-and-branch, relative and register jumps, jump-and-link, and loads and stores of words, halfwords and bytes.

The core does no lane steering itself. For a load, an external load/store unit returns the data already moved to the low bits and already extended. For a store, that unit picks the bytes it needs from the full register value. The core's part is to supply the effective address, the size code and the sign-extension request.

Any opcode outside the defined set parks the controller in a halt state. The core then stays silent on the bus until reset.

Top module: `rsc_core`

## Requirements
- R1: On synchronous reset the program counter becomes 0 and `halted` is low. The first cycle after reset issues a word-size read (`bus_size` = 2'b10) at address 0.
- R2: Register-register forms use these fields: opcode in [31:26], first source in [25:21], second source in [20:16] and destination in [15:11]. Opcode 0x00 writes the sum, 0x02 the difference (first minus second), 0x10 AND, 0x12 OR, 0x14 XOR and 0x16 XNOR. Results wrap modulo 2^32.
- R3: Immediate forms use these fields: source in [25:21], destination in [20:16] and a 16-bit immediate in [15:0]. Opcodes 0x01 and 0x03 add and subtract the sign-extended immediate. Opcodes 0x11, 0x13, 0x15 and 0x17 apply AND, OR, XOR and XNOR with the zero-extended immediate.
- R4: Opcode 0x1F writes the destination in [20:16] with the immediate in the upper half and zero in the lower half.
- R5: Register 0 always reads as zero, and writes to it are discarded.
- R6: The branch opcodes compare the register in [25:21] with the register in [20:16]. Opcode 0x20 branches when they are equal, 0x21 when they differ, 0x23 when the first is unsigned less-or-equal, 0x25 unsigned less-than, 0x27 unsigned greater-or-equal and 0x29 unsigned greater-than. A taken branch goes to the address of the next instruction plus the sign-extended [15:0] times 4. An untaken branch falls through.
- R7: Opcode 0x2A jumps to the address of the next instruction plus the sign-extended [25:0] times 4. Opcode 0x2C does the same and also writes the address of the next instruction into register 31. Opcode 0x2B jumps to the value of the register in [25:21].
- R8: Loads (opcodes 0x30 to 0x34) read at the address formed by the register in [25:21] plus the sign-extended [15:0]. They write the returned `bus_rdata` unchanged into the register in [20:16]. Size codes are 2'b10 word (0x30), 2'b01 halfword (0x31, 0x32) and 2'b00 byte (0x33, 0x34). `bus_sext` is high only for 0x31 and 0x33.
- R9: Stores (0x35 word, 0x36 halfword, 0x37 byte, same size codes) form the address as in R8. They drive the full value of the register in [20:16] on `bus_wdata` with `bus_wr` high.
- R10: While a read or write waits for `bus_ready`, the address, strobes and write data hold steady.
- R11: An undefined opcode (for example 0x22) moves the core to a halt state. There `halted` is high and no read or write is issued. Only reset leaves that state.
- R12: `bus_rd` and `bus_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | output | 32 | Byte address of the current access |
| bus_rd | output | 1 | Read request (fetch or load) |
| bus_wr | output | 1 | Write request (store) |
| bus_size | output | 2 | Access size: 2'b10 word, 2'b01 halfword, 2'b00 byte |
| bus_sext | output | 1 | Sign-extension request for sub-word loads |
| bus_wdata | output | 32 | Store data, full register value |
| bus_rdata | input | 32 | Read data, already aligned and extended |
| bus_ready | input | 1 | Access completes on a rising edge with this high |
| halted | output | 1 | Core is stuck on an undefined opcode |

## Verification
The bench assembles one long program. Every result is stored to a distinct address, so the sequence of bus writes reveals each result. The six register-register and six immediate operations are swept over all pairs drawn from a set of corner words: zero, one, all ones, the sign bit alone, the largest positive value and a mixed pattern. Immediates that cross the sign boundary (0x8000, 0xFFFF) show whether sign extension and zero extension were mixed up. All six branch conditions are tried on the same operand pairs, including equal pairs and pairs that differ only in the top bit. These cases separate unsigned from signed comparison and strict from non-strict comparison. A backward-branching loop, the three jumps, loads at every lane and sign and a randomly stalled ready line cover target arithmetic and wait-state holding.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
  } rsc_state_t;

  typedef enum logic [2:0] {
    AL_ADD, AL_SUB, AL_AND, AL_OR, AL_XOR, AL_XNOR, AL_UPPER
  } rsc_alu_t;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam logic [5:0] OPC_LDHI = 6'h1F;
  localparam logic [5:0] OPC_J    = 6'h2A;
  localparam logic [5:0] OPC_JR   = 6'h2B;
  localparam logic [5:0] OPC_JAL  = 6'h2C;
  localparam logic [5:0] OPC_LDH  = 6'h31;
  localparam logic [5:0] OPC_LDB  = 6'h33;

  function automatic logic [1:0] mem_size(input logic [5:0] opc);
    case (opc)
      6'h30, 6'h35:         mem_size = SZ_WORD;
      6'h31, 6'h32, 6'h36:  mem_size = SZ_HALF;
      default:              mem_size = SZ_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/rsc_regfile.sv
module rsc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [RAW-1:0]  ra_a,
  input  logic [RAW-1:0]  ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  input  logic            we,
  input  logic [RAW-1:0]  wa,
  input  logic [XLEN-1:0] wd
);

  logic [XLEN-1:0] mem [NREG];

  // Registered reads so the array maps onto a dual-read block RAM;
  // entry 0 is never written and is masked on the read side.
  always_ff @(posedge clk) begin
    if (we && wa != '0) mem[wa] <= wd;
    rd_a <= (ra_a == '0) ? '0 : mem[ra_a];
    rd_b <= (ra_b == '0) ? '0 : mem[ra_b];
  end

endmodule

// File: rtl/rsc_alu.sv
module rsc_alu import rsc_pkg::*; #(
  parameter int XLEN = 32,
  localparam int HALF = XLEN / 2
) (
  input  rsc_alu_t        op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  always_comb begin
    case (op)
      AL_ADD:   y = a + b;
      AL_SUB:   y = a - b;
      AL_AND:   y = a & b;
      AL_OR:    y = a | b;
      AL_XOR:   y = a ^ b;
      AL_XNOR:  y = ~(a ^ b);
      AL_UPPER: y = {b[HALF-1:0], {HALF{1'b0}}};
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/rsc_cmp.sv
module rsc_cmp #(
  parameter int XLEN = 32
) (
  input  logic [3:0]      cond,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            take
);

  // Condition code is the low nibble of the branch opcode.
  always_comb begin
    case (cond)
      4'h0:    take = (a == b);
      4'h1:    take = (a != b);
      4'h3:    take = (a <= b);
      4'h5:    take = (a <  b);
      4'h7:    take = (a >= b);
      4'h9:    take = (a >  b);
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/rsc_core.sv
module rsc_core import rsc_pkg::*; #(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] bus_addr,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic [1:0]      bus_size,
  output logic            bus_sext,
  output logic [XLEN-1:0] bus_wdata,
  input  logic [XLEN-1:0] bus_rdata,
  input  logic            bus_ready,
  output logic            halted
);

  localparam int RAW = $clog2(NREG);
  localparam logic [RAW-1:0] LINK = RAW'(NREG - 1);

  rsc_state_t      state_q;
  logic [XLEN-1:0] pc_q, ir_q, mar_q, wdata_q, res_q;
  logic [RAW-1:0]  dest_q;

  // ---------------- decode (from the instruction register) -------------
  logic [5:0]      opc;
  logic            is_rrr, is_rri, is_hi, is_br, is_ld, is_st, known;
  logic [XLEN-1:0] imm_s, imm_z, off_b, off_j, alu_b, alu_y, rf_a, rf_b;
  rsc_alu_t        alu_op;
  logic            take;

  assign opc    = ir_q[31:26];
  assign is_rrr = opc inside {6'h00, 6'h02, 6'h10, 6'h12, 6'h14, 6'h16};
  assign is_rri = opc inside {6'h01, 6'h03, 6'h11, 6'h13, 6'h15, 6'h17};
  assign is_hi  = (opc == OPC_LDHI);
  assign is_br  = opc inside {6'h20, 6'h21, 6'h23, 6'h25, 6'h27, 6'h29};
  assign is_ld  = opc inside {[6'h30:6'h34]};
  assign is_st  = opc inside {[6'h35:6'h37]};
  assign known  = is_rrr | is_rri | is_hi | is_br | is_ld | is_st |
                  (opc == OPC_J) | (opc == OPC_JR) | (opc == OPC_JAL);

  assign imm_s = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign imm_z = {{(XLEN-16){1'b0}}, ir_q[15:0]};
  assign off_b = {{(XLEN-18){ir_q[15]}}, ir_q[15:0], 2'b00};
  assign off_j = {{(XLEN-28){ir_q[25]}}, ir_q[25:0], 2'b00};

  always_comb begin
    if (is_hi)               alu_op = AL_UPPER;
    else if (is_ld || is_st) alu_op = AL_ADD;
    else if (opc[4]) begin
      case (opc[2:1])
        2'd0:    alu_op = AL_AND;
        2'd1:    alu_op = AL_OR;
        2'd2:    alu_op = AL_XOR;
        default: alu_op = AL_XNOR;
      endcase
    end
    else alu_op = opc[1] ? AL_SUB : AL_ADD;
  end

  assign alu_b = is_rrr ? rf_b : ((is_ld || is_st || !opc[4]) ? imm_s : imm_z);

  rsc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .ra_a(ir_q[21 +: RAW]),
    .ra_b(ir_q[16 +: RAW]),
    .rd_a(rf_a),
    .rd_b(rf_b),
    .we  (state_q == ST_WB),
    .wa  (dest_q),
    .wd  (res_q)
  );

  rsc_alu #(.XLEN(XLEN)) u_alu (.op(alu_op), .a(rf_a), .b(alu_b), .y(alu_y));

  rsc_cmp #(.XLEN(XLEN)) u_cmp (.cond(opc[3:0]), .a(rf_a), .b(rf_b), .take(take));

  // ---------------- controller ----------------------------------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      mar_q   <= '0;
      wdata_q <= '0;
      res_q   <= '0;
      dest_q  <= '0;
    end else begin
      case (state_q)
        ST_FETCH: if (bus_ready) begin
          ir_q    <= bus_rdata;
          pc_q    <= pc_q + XLEN'(4);
          state_q <= ST_DECODE;
        end
        ST_DECODE: state_q <= known ? ST_EXEC : ST_HALT;
        ST_EXEC: begin
          state_q <= ST_FETCH;
          if (is_rrr || is_rri || is_hi) begin
            res_q   <= alu_y;
            dest_q  <= is_rrr ? ir_q[11 +: RAW] : ir_q[16 +: RAW];
            state_q <= ST_WB;
          end else if (is_ld || is_st) begin
            mar_q   <= alu_y;
            wdata_q <= rf_b;
            dest_q  <= ir_q[16 +: RAW];
            state_q <= ST_MEM;
          end else if (is_br) begin
            if (take) pc_q <= pc_q + off_b;
          end else if (opc == OPC_JR) begin
            pc_q <= rf_a;
          end else begin
            pc_q <= pc_q + off_j;
            if (opc == OPC_JAL) begin
              res_q   <= pc_q;
              dest_q  <= LINK;
              state_q <= ST_WB;
            end
          end
        end
        ST_MEM: if (bus_ready) begin
          res_q   <= bus_rdata;
          state_q <= is_ld ? ST_WB : ST_FETCH;
        end
        ST_WB:   state_q <= ST_FETCH;
        default: state_q <= ST_HALT;
      endcase
    end
  end

  // ---------------- bus drive (decoded from registers only) ------------
  assign bus_addr  = (state_q == ST_FETCH) ? pc_q : mar_q;
  assign bus_rd    = (state_q == ST_FETCH) || (state_q == ST_MEM && is_ld);
  assign bus_wr    = (state_q == ST_MEM) && is_st;
  assign bus_size  = (state_q == ST_FETCH) ? SZ_WORD : mem_size(opc);
  assign bus_sext  = (state_q == ST_MEM) && (opc == OPC_LDH || opc == OPC_LDB);
  assign bus_wdata = wdata_q;
  assign halted    = (state_q == ST_HALT);

  // ---------------- assertions ----------------------------------------
  a_r1_first_fetch: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> bus_rd && bus_addr == RESET_PC && bus_size == SZ_WORD);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) && !bus_ready |=>
      $stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr) && $stable(bus_wdata));

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> !bus_rd && !bus_wr);

  a_r12_one_cmd: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

endmodule

// File: tb/sim_rsc_core.sv
`timescale 1ns/1ps
module sim_rsc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_rd, bus_wr, bus_sext, halted;
  logic        bus_ready = 1'b0;
  logic [1:0]  bus_size;

  always #2.5 clk = ~clk;

  rsc_core u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_sext(bus_sext), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .halted(halted)
  );

  int checks = 0;
  int fails  = 0;

  logic [31:0] mem [0:4095];

  // Bench model of the external load/store unit (little-endian lanes).
  always_comb begin
    logic [31:0] w;
    logic [15:0] h;
    logic [7:0]  b;
    w = mem[bus_addr[13:2]];
    h = bus_addr[1] ? w[31:16] : w[15:0];
    b = 8'(w >> (8 * bus_addr[1:0]));
    case (bus_size)
      2'b10:   bus_rdata = w;
      2'b01:   bus_rdata = bus_sext ? {{16{h[15]}}, h} : {16'h0, h};
      default: bus_rdata = bus_sext ? {{24{b[7]}}, b} : {24'h0, b};
    endcase
  end

  // ---------------- program builder ----------------------------------
  int          pcw  = 0;
  int          nexp = 0;
  int          nlog = 0;
  logic [31:0] exp_addr [0:2047];
  logic [31:0] exp_data [0:2047];
  logic [1:0]  exp_size [0:2047];
  string       exp_req  [0:2047];
  logic [31:0] log_addr [0:2047];
  logic [31:0] log_data [0:2047];
  logic [1:0]  log_size [0:2047];

  function automatic logic [31:0] f_rrr(int op, int s1, int s2, int d);
    return {op[5:0], s1[4:0], s2[4:0], d[4:0], 11'b0};
  endfunction

  function automatic logic [31:0] f_ri(int op, int s, int d, logic [15:0] imm);
    return {op[5:0], s[4:0], d[4:0], imm};
  endfunction

  function automatic logic [31:0] f_jmp(int op, logic [25:0] off);
    return {op[5:0], off};
  endfunction

  task automatic put(input logic [31:0] w);
    mem[pcw] = w;
    pcw++;
  endtask

  task automatic ldc(input int r, input logic [31:0] v);
    put(f_ri(6'h1F, 0, r, v[31:16]));
    put(f_ri(6'h13, r, r, v[15:0]));
  endtask

  task automatic exp_st(input int op, input int base, input int src, input logic [15:0] imm,
                        input logic [31:0] addr, input logic [31:0] data, input string req);
    put(f_ri(op, base, src, imm));
    exp_addr[nexp] = addr;
    exp_data[nexp] = data;
    exp_size[nexp] = (op == 6'h35) ? 2'b10 : (op == 6'h36) ? 2'b01 : 2'b00;
    exp_req[nexp]  = req;
    nexp++;
  endtask

  task automatic chk_st(input int src, input logic [31:0] data, input string req);
    logic [31:0] a;
    a = 32'h4000 + 32'(nexp * 4);
    exp_st(6'h35, 0, src, a[15:0], a, data, req);
  endtask

  function automatic logic [31:0] ref_rr(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      0:       return a + b;
      2:       return a - b;
      16:      return a & b;
      18:      return a | b;
      20:      return a ^ b;
      default: return ~(a ^ b);
    endcase
  endfunction

  function automatic logic [31:0] ref_ri(int op, logic [31:0] a, logic [15:0] imm);
    logic [31:0] b;
    b = (op < 4) ? {{16{imm[15]}}, imm} : {16'h0, imm};
    return ref_rr(op - 1, a, b);
  endfunction

  function automatic logic ref_br(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      32:      return a == b;
      33:      return a != b;
      35:      return a <= b;
      37:      return a < b;
      39:      return a >= b;
      default: return a > b;
    endcase
  endfunction

  function automatic logic [31:0] ref_ld(int op, logic [31:0] addr);
    logic [31:0] w;
    logic [15:0] h;
    logic [7:0]  b;
    w = mem[addr[13:2]];
    h = addr[1] ? w[31:16] : w[15:0];
    b = 8'(w >> (8 * addr[1:0]));
    case (op)
      6'h30:   return w;
      6'h31:   return {{16{h[15]}}, h};
      6'h32:   return {16'h0, h};
      6'h33:   return {{24{b[7]}}, b};
      default: return {24'h0, b};
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'hA5A5_0F0F};
  logic [15:0] imms [5] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h7FFE};
  int rr_ops [6] = '{0, 2, 16, 18, 20, 22};
  int ri_ops [6] = '{1, 3, 17, 19, 21, 23};
  int br_ops [6] = '{32, 33, 35, 37, 39, 41};

  task automatic build;
    int p;
    for (int k = 0; k < 4096; k++) mem[k] = 32'h0;
    mem[12'hC00] = 32'h8123_F4A5;
    mem[12'hC01] = 32'h7F80_1234;
    // R2: register-register sweep
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        ldc(1, vals[i]);
        ldc(2, vals[j]);
        for (int k = 0; k < 6; k++) begin
          put(f_rrr(rr_ops[k], 1, 2, 3));
          chk_st(3, ref_rr(rr_ops[k], vals[i], vals[j]), "R2");
        end
      end
    // R3: immediate sweep
    for (int i = 0; i < 6; i++) begin
      ldc(1, vals[i]);
      for (int m = 0; m < 5; m++)
        for (int k = 0; k < 6; k++) begin
          put(f_ri(ri_ops[k], 1, 4, imms[m]));
          chk_st(4, ref_ri(ri_ops[k], vals[i], imms[m]), "R3");
        end
    end
    // R4: upper-half load
    for (int m = 0; m < 5; m++) begin
      put(f_ri(6'h1F, 0, 5, imms[m]));
      chk_st(5, {imms[m], 16'h0}, "R4");
    end
    // R5: register zero
    ldc(1, vals[5]);
    ldc(2, 32'h1);
    put(f_rrr(0, 1, 2, 0));
    chk_st(0, 32'h0, "R5");
    put(f_ri(6'h01, 0, 6, 16'h0005));
    chk_st(6, 32'h5, "R5");
    // R6: conditional branches, forward by one
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        ldc(1, vals[i]);
        ldc(2, vals[j]);
        for (int k = 0; k < 6; k++) begin
          put(f_ri(6'h01, 0, 5, 16'h0));
          put(f_ri(br_ops[k], 1, 2, 16'h0001));
          put(f_ri(6'h01, 0, 5, 16'h0001));
          chk_st(5, ref_br(br_ops[k], vals[i], vals[j]) ? 32'h0 : 32'h1, "R6");
        end
      end
    // R6: backward branch loop, three passes
    put(f_ri(6'h01, 0, 7, 16'h3));
    put(f_ri(6'h01, 0, 8, 16'h0));
    put(f_ri(6'h01, 8, 8, 16'h1));
    put(f_ri(6'h03, 7, 7, 16'h1));
    put(f_ri(6'h21, 7, 0, 16'hFFFD));
    chk_st(8, 32'h3, "R6");
    chk_st(7, 32'h0, "R6");
    // R7: jumps
    put(f_ri(6'h01, 0, 9, 16'h0));
    put(f_jmp(6'h2A, 26'h1));
    put(f_ri(6'h01, 0, 9, 16'h0077));
    chk_st(9, 32'h0, "R7");
    p = pcw;
    put(f_jmp(6'h2C, 26'h1));
    put(f_ri(6'h01, 0, 9, 16'h0055));
    chk_st(31, 32'(p * 4 + 4), "R7");
    chk_st(9, 32'h0, "R7");
    p = pcw;
    ldc(6, 32'((p + 4) * 4));
    put({6'h2B, 5'd6, 21'h0});
    put(f_ri(6'h01, 0, 9, 16'h0066));
    chk_st(9, 32'h0, "R7");
    // R8: loads from base 0x3010 with negative offsets
    ldc(10, 32'h3010);
    begin
      int          lop  [11] = '{6'h30, 6'h30, 6'h31, 6'h32, 6'h31, 6'h32, 6'h33, 6'h34, 6'h33, 6'h33, 6'h34};
      logic [31:0] ladr [11] = '{32'h3000, 32'h3004, 32'h3000, 32'h3000, 32'h3002, 32'h3006,
                                 32'h3000, 32'h3000, 32'h3001, 32'h3006, 32'h3007};
      for (int k = 0; k < 11; k++) begin
        logic [31:0] off;
        off = ladr[k] - 32'h3010;
        put(f_ri(lop[k], 10, 11, off[15:0]));
        chk_st(11, ref_ld(lop[k], ladr[k]), "R8");
      end
    end
    // R9: store sizes and a based store
    ldc(12, 32'hDEAD_BEEF);
    exp_st(6'h36, 0, 12, 16'h5000, 32'h5000, 32'hDEAD_BEEF, "R9");
    exp_st(6'h37, 0, 12, 16'h5001, 32'h5001, 32'hDEAD_BEEF, "R9");
    exp_st(6'h35, 10, 12, 16'hFFFC, 32'h300C, 32'hDEAD_BEEF, "R9");
    // R11: undefined opcode, followed by a store that must never run
    put(32'h8800_0000);
    put(f_ri(6'h35, 0, 12, 16'h7000));
  endtask

  // ---------------- run ----------------------------------------------
  logic [15:0] lfsr = 16'hACE1;
  logic        pend;
  logic [31:0] pend_addr;
  logic        pend_rd, pend_wr;
  int          quiet_bad;

  initial begin
    build();
    repeat (3) @(negedge clk);
    check(!halted && !bus_wr, "R1", "halted/wr in reset", {30'h0, halted, bus_wr}, 32'h0);
    rst = 1'b0;
    check(bus_rd && bus_addr == 32'h0 && bus_size == 2'b10, "R1", "first fetch addr",
          bus_addr, 32'h0);
    pend = 1'b0;
    for (int cyc = 0; cyc < 150000 && !halted; cyc++) begin
      @(negedge clk);
      if (pend)
        check(bus_addr == pend_addr && bus_rd == pend_rd && bus_wr == pend_wr,
              "R10", "stall hold addr", bus_addr, pend_addr);
      check(!(bus_rd && bus_wr), "R12", "rd and wr together", {30'h0, bus_rd, bus_wr}, 32'h0);
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_ready = lfsr[0] | lfsr[3];
      if (bus_wr && bus_ready && nlog < 2048) begin
        log_addr[nlog] = bus_addr;
        log_data[nlog] = bus_wdata;
        log_size[nlog] = bus_size;
        nlog++;
      end
      pend      = (bus_rd || bus_wr) && !bus_ready;
      pend_addr = bus_addr;
      pend_rd   = bus_rd;
      pend_wr   = bus_wr;
    end
    check(halted, "R11", "watchdog: halt not reached", {31'h0, halted}, 32'h1);

    quiet_bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (!halted || bus_rd || bus_wr) quiet_bad++;
    end
    check(quiet_bad == 0, "R11", "bus quiet while halted", 32'(quiet_bad), 32'h0);
    check(nlog == nexp, "R11", "store count", 32'(nlog), 32'(nexp));

    for (int k = 0; k < nexp && k < nlog; k++) begin
      check(log_addr[k] == exp_addr[k], exp_req[k], "store addr", log_addr[k], exp_addr[k]);
      check(log_data[k] == exp_data[k], exp_req[k], "store data", log_data[k], exp_data[k]);
      check(log_size[k] == exp_size[k], exp_req[k], "store size", 32'(log_size[k]), 32'(exp_size[k]));
    end

    bus_ready = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(!halted && bus_rd && bus_addr == 32'h0, "R11", "reset leaves halt", bus_addr, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule